// File: doc/BRIEF.md
# Drive Ready Poll Sequencer

This block keeps watch over the ready lines of four disk drives while the controller has no read or write in progress. It walks through the drives in the fixed order drive 1, drive 2, drive 4, drive 3, and gives each drive a time slot. While a slot is open it drives a one-hot select for that drive. When the slot closes it compares the ready level of that drive with a stored copy. A difference raises an interrupt request and latches which drive changed.

Every reset clears the stored copy to not-ready. A drive that is ready when it is next visited therefore produces an interrupt after each reset. Polling starts by itself once reset is released.

Two things can suspend the scan: a command-busy flag and a read/write-active flag. A slot that is cut short is abandoned, and the scan resumes at the next drive. A configuration strobe captures two settings: a minifloppy flag that doubles the slot length, and a PC AT flag that hides the scan from the select outputs. A hardware reset clears both settings. A soft reset keeps them.

Top module: `readyPoller`

## Requirements
- R1: After a hardware or soft reset, readySnap is 0000, irqOut is 0 and changedIdx is 0. Polling starts at drive 1 with no further input.
- R2: driveSel bit n selects drive n+1. While polling is visible, driveSel takes the values 0001, 0010, 1000, 0100 in turn and then repeats.
- R3: Each slot lasts SCAN_CYCLES/4 clock cycles at standard rate and SCAN_CYCLES/2 in minifloppy mode. The first slot after reset ends on the SCAN_CYCLES/4-th (or SCAN_CYCLES/2-th) rising edge.
- R4: On the edge that closes a slot, the block checks the visited drive's readyIn bit against its readySnap bit. If they differ and irqOut is low, the edge sets irqOut, loads changedIdx with the drive number minus one, and copies the new level into readySnap.
- R5: While irqOut is high, readySnap does not change. A change on another drive is reported on that drive's first visit after the clear, so several changes are reported one at a time in scan order.
- R6: A high irqClear at a clock edge drops irqOut at that edge. Without it, irqOut stays high.
- R7: While cmdBusy or rwActive is high, no sampling happens and driveSel equals cmdSel. If a slot was partly done, the scan resumes at the next drive in the order with a full slot.
- R8: In PC AT mode, driveSel always equals cmdSel, but sampling and interrupts go on as usual.
- R9: Hardware reset sets base mode (PC AT off) and standard rate. Soft reset leaves both settings unchanged.
- R10: A high cfgLoad at a clock edge captures atMode and miniRate as the active settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hwRst | input | 1 | Asynchronous hardware reset, active high |
| softRst | input | 1 | Synchronous soft reset, active high |
| cmdBusy | input | 1 | A command is executing |
| rwActive | input | 1 | A read or write is active |
| cfgLoad | input | 1 | Captures atMode and miniRate |
| miniRate | input | 1 | Minifloppy rate request |
| atMode | input | 1 | PC AT mode request |
| cmdSel | input | 4 | Command-driven drive selects |
| readyIn | input | 4 | Ready lines, bit n is drive n+1 |
| irqClear | input | 1 | Clears the interrupt |
| driveSel | output | 4 | Drive select outputs |
| irqOut | output | 1 | Ready-change interrupt |
| changedIdx | output | 2 | Index of the drive that changed |
| readySnap | output | 4 | Stored ready levels |

## Verification
The select output depends only on state and the busy flags, so it can be read in the same cycle as a busy change. Across a scan it moves on the edges that are multiples of the slot length after reset. The interrupt, changedIdx and readySnap change on the edge that closes the sampled slot, which is edge k·slot after reset. The bench counts rising edges from the release of reset, drives inputs and samples at falling edges, and checks each result exactly one edge before and on its due edge.

// File: rtl/pollPkg.sv
package pollPkg;
  localparam int DRIVE_CNT = 4;
  localparam int IDX_W = 2;

  typedef struct packed {
    logic active;
    logic tick;
  } pollStrobe_t;
endpackage

// File: rtl/pollCtrl.sv
module pollCtrl
  import pollPkg::*;
#(
  parameter int SCAN_CYCLES = 16384
) (
  input  logic             clk,
  input  logic             hwRst,
  input  logic             softRst,
  input  logic             cmdBusy,
  input  logic             rwActive,
  input  logic             miniCfg,
  output pollStrobe_t      strobe,
  output logic [IDX_W-1:0] curDrive
);
  localparam int SLOT_STD = SCAN_CYCLES / DRIVE_CNT;
  localparam int SLOT_MINI = 2 * SLOT_STD;
  localparam int CNT_W = $clog2(SLOT_MINI);
  localparam logic [CNT_W-1:0] LIM_STD = CNT_W'(SLOT_STD - 1);
  localparam logic [CNT_W-1:0] LIM_MINI = CNT_W'(SLOT_MINI - 1);

  logic [CNT_W-1:0] slotCnt;
  logic [IDX_W-1:0] scanPos;
  logic [CNT_W-1:0] slotLimit;
  logic             isActive;
  logic             slotEnd;
  logic             slotCut;

  assign isActive  = !cmdBusy && !rwActive;
  assign slotLimit = miniCfg ? LIM_MINI : LIM_STD;
  assign slotEnd   = isActive && (slotCnt >= slotLimit);
  assign slotCut   = !isActive && (slotCnt != '0);

  // position 0,1,2,3 -> drive index 0,1,3,2 (Gray code)
  assign curDrive = scanPos ^ {1'b0, scanPos[IDX_W-1]};

  assign strobe.active = isActive;
  assign strobe.tick   = slotEnd;

  always_ff @(posedge clk or posedge hwRst) begin
    if (hwRst) begin
      slotCnt <= '0;
      scanPos <= '0;
    end else if (softRst) begin
      slotCnt <= '0;
      scanPos <= '0;
    end else if (slotEnd || slotCut) begin
      slotCnt <= '0;
      scanPos <= scanPos + IDX_W'(1);
    end else if (isActive) begin
      slotCnt <= slotCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pollData.sv
module pollData
  import pollPkg::*;
(
  input  logic                 clk,
  input  logic                 hwRst,
  input  logic                 softRst,
  input  pollStrobe_t          strobe,
  input  logic [IDX_W-1:0]     curDrive,
  input  logic [DRIVE_CNT-1:0] readyIn,
  input  logic                 irqClear,
  input  logic                 atCfg,
  input  logic [DRIVE_CNT-1:0] cmdSel,
  output logic [DRIVE_CNT-1:0] driveSel,
  output logic                 irqOut,
  output logic [IDX_W-1:0]     changedIdx,
  output logic [DRIVE_CNT-1:0] readySnap
);
  logic sampled;
  logic differs;

  assign sampled = readyIn[curDrive];
  assign differs = sampled != readySnap[curDrive];

  always_comb begin
    if (strobe.active && !atCfg) driveSel = DRIVE_CNT'(1) << curDrive;
    else                         driveSel = cmdSel;
  end

  always_ff @(posedge clk or posedge hwRst) begin
    if (hwRst) begin
      readySnap  <= '0;
      irqOut     <= 1'b0;
      changedIdx <= '0;
    end else if (softRst) begin
      readySnap  <= '0;
      irqOut     <= 1'b0;
      changedIdx <= '0;
    end else if (strobe.tick && differs && !irqOut) begin
      irqOut              <= 1'b1;
      changedIdx          <= curDrive;
      readySnap[curDrive] <= sampled;
    end else if (irqClear) begin
      irqOut <= 1'b0;
    end
  end
endmodule

// File: rtl/readyPoller.sv
module readyPoller
  import pollPkg::*;
#(
  parameter int SCAN_CYCLES = 16384
) (
  input  logic       clk,
  input  logic       hwRst,
  input  logic       softRst,
  input  logic       cmdBusy,
  input  logic       rwActive,
  input  logic       cfgLoad,
  input  logic       miniRate,
  input  logic       atMode,
  input  logic [3:0] cmdSel,
  input  logic [3:0] readyIn,
  input  logic       irqClear,
  output logic [3:0] driveSel,
  output logic       irqOut,
  output logic [1:0] changedIdx,
  output logic [3:0] readySnap
);
  logic             atCfg;
  logic             miniCfg;
  pollStrobe_t      strobe;
  logic [IDX_W-1:0] curDrive;

  // settings survive soft reset; only hardware reset returns to base
  always_ff @(posedge clk or posedge hwRst) begin
    if (hwRst) begin
      atCfg   <= 1'b0;
      miniCfg <= 1'b0;
    end else if (cfgLoad) begin
      atCfg   <= atMode;
      miniCfg <= miniRate;
    end
  end

  pollCtrl #(.SCAN_CYCLES(SCAN_CYCLES)) i_ctrl (
    .clk      (clk),
    .hwRst    (hwRst),
    .softRst  (softRst),
    .cmdBusy  (cmdBusy),
    .rwActive (rwActive),
    .miniCfg  (miniCfg),
    .strobe   (strobe),
    .curDrive (curDrive)
  );

  pollData i_data (
    .clk        (clk),
    .hwRst      (hwRst),
    .softRst    (softRst),
    .strobe     (strobe),
    .curDrive   (curDrive),
    .readyIn    (readyIn),
    .irqClear   (irqClear),
    .atCfg      (atCfg),
    .cmdSel     (cmdSel),
    .driveSel   (driveSel),
    .irqOut     (irqOut),
    .changedIdx (changedIdx),
    .readySnap  (readySnap)
  );
endmodule

// File: rtl/pollChecker.sv
module pollChecker (
  input logic       clk,
  input logic       hwRst,
  input logic       softRst,
  input logic       cmdBusy,
  input logic       rwActive,
  input logic       irqClear,
  input logic       atCfg,
  input logic [3:0] cmdSel,
  input logic [3:0] driveSel,
  input logic       irqOut,
  input logic [3:0] readySnap
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (hwRst)
    (!cmdBusy && !rwActive && !atCfg) |-> ($countones(driveSel) == 1)); // R2
  AST_IDLE_SEL: assert property (@(posedge clk) disable iff (hwRst)
    (cmdBusy || rwActive) |-> (driveSel == cmdSel)); // R7
  AST_IDLE_SNAP: assert property (@(posedge clk) disable iff (hwRst)
    ((cmdBusy || rwActive) && !softRst) |=> $stable(readySnap)); // R7
  AST_IRQ_SNAP: assert property (@(posedge clk) disable iff (hwRst)
    $rose(irqOut) |-> (readySnap != $past(readySnap))); // R4
  AST_PENDING_FREEZE: assert property (@(posedge clk) disable iff (hwRst)
    (irqOut && !softRst) |=> $stable(readySnap)); // R5
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (hwRst)
    (irqOut && !irqClear && !softRst) |=> irqOut); // R6
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (hwRst)
    irqClear |=> !irqOut); // R6
endmodule

bind readyPoller pollChecker i_pollChecker (
  .clk       (clk),
  .hwRst     (hwRst),
  .softRst   (softRst),
  .cmdBusy   (cmdBusy),
  .rwActive  (rwActive),
  .irqClear  (irqClear),
  .atCfg     (atCfg),
  .cmdSel    (cmdSel),
  .driveSel  (driveSel),
  .irqOut    (irqOut),
  .readySnap (readySnap)
);

// File: tb/test_readyPoller.sv
`timescale 1ns/1ps
module test_readyPoller;
  localparam int SCAN = 16;
  localparam int SLOT = SCAN / 4;

  logic clk = 1'b0;
  logic hwRst = 1'b1, softRst = 1'b0, cmdBusy = 1'b0, rwActive = 1'b0;
  logic cfgLoad = 1'b0, miniRate = 1'b0, atMode = 1'b0, irqClear = 1'b0;
  logic [3:0] cmdSel = 4'b0000, readyIn = 4'b0000;
  logic [3:0] driveSel, readySnap;
  logic       irqOut;
  logic [1:0] changedIdx;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  readyPoller #(.SCAN_CYCLES(SCAN)) i_readyPoller (
    .clk(clk), .hwRst(hwRst), .softRst(softRst), .cmdBusy(cmdBusy),
    .rwActive(rwActive), .cfgLoad(cfgLoad), .miniRate(miniRate),
    .atMode(atMode), .cmdSel(cmdSel), .readyIn(readyIn),
    .irqClear(irqClear), .driveSel(driveSel), .irqOut(irqOut),
    .changedIdx(changedIdx), .readySnap(readySnap)
  );

  // scan position -> drive index, order 1,2,4,3
  function automatic logic [3:0] expSel(int slotNo);
    int order [4] = '{0, 1, 3, 2};
    return 4'b0001 << order[slotNo % 4];
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic softReset();
    softRst = 1'b1; step(1); softRst = 1'b0;
  endtask

  task automatic clearIrq();
    irqClear = 1'b1; step(1); irqClear = 1'b0;
  endtask

  task automatic loadCfg(logic at, logic mini);
    atMode = at; miniRate = mini; cfgLoad = 1'b1; step(1); cfgLoad = 1'b0;
  endtask

  initial begin
    logic [3:0] snapKeep;
    step(2);
    hwRst = 1'b0;
    // R1 reset state
    check("R1 irq", 8'(irqOut), 8'h0);
    check("R1 snap", 8'(readySnap), 8'h0);
    check("R1 idx", 8'(changedIdx), 8'h0);
    // R2 R3 order and slot length over two scans
    for (int e = 0; e < 8 * SLOT; e++) begin
      check("R2 R3 sel", 8'(driveSel), 8'(expSel(e / SLOT)));
      step(1);
    end
    check("R2 no irq", 8'(irqOut), 8'h0);
    // R4 detection at slot end (edge 36 closes slot 8, drive 1)
    readyIn = 4'b1111;
    step(SLOT - 1);
    check("R4 before edge", 8'(irqOut), 8'h0);
    step(1);
    check("R4 irq", 8'(irqOut), 8'h1);
    check("R4 idx", 8'(changedIdx), 8'h0);
    check("R4 snap", 8'(readySnap), 8'h1);
    step(SLOT);
    check("R5 frozen", 8'(readySnap), 8'h1);
    check("R6 held", 8'(irqOut), 8'h1);
    clearIrq();
    check("R6 cleared", 8'(irqOut), 8'h0);
    step(SLOT - 1);  // edge 44: drive 4
    check("R5 next irq", 8'(irqOut), 8'h1);
    check("R5 idx drive4", 8'(changedIdx), 8'h3);
    check("R5 snap", 8'(readySnap), 8'h9);
    clearIrq();
    step(SLOT - 1);  // edge 48: drive 3
    check("R5 idx drive3", 8'(changedIdx), 8'h2);
    check("R5 snap", 8'(readySnap), 8'hD);
    clearIrq();
    step(SLOT - 1);  // edge 52: drive 1 unchanged
    check("R4 no change", 8'(irqOut), 8'h0);
    step(SLOT);      // edge 56: drive 2
    check("R5 idx drive2", 8'(changedIdx), 8'h1);
    check("R5 snap", 8'(readySnap), 8'hF);
    clearIrq();
    // R1 soft reset forces not-ready, interrupt follows
    softReset();
    check("R1 soft snap", 8'(readySnap), 8'h0);
    check("R1 soft irq", 8'(irqOut), 8'h0);
    check("R1 soft sel", 8'(driveSel), 8'h1);
    step(SLOT);
    check("R1 irq after reset", 8'(irqOut), 8'h1);
    check("R1 idx", 8'(changedIdx), 8'h0);
    clearIrq();      // edge 5: drive 2 slot partly done
    // R7 busy suspends, resumes at next drive
    cmdSel = 4'b0110; cmdBusy = 1'b1;
    step(1);
    check("R7 busy sel", 8'(driveSel), 8'h6);
    step(4);
    check("R7 no sample", 8'(readySnap), 8'h1);
    check("R7 no irq", 8'(irqOut), 8'h0);
    cmdBusy = 1'b0;
    #0.1;
    check("R7 resume drive4", 8'(driveSel), 8'h8);
    step(SLOT - 1);
    check("R7 full slot", 8'(irqOut), 8'h0);
    step(1);
    check("R7 irq drive4", 8'(changedIdx), 8'h3);
    check("R7 irq", 8'(irqOut), 8'h1);
    check("R2 after drive4", 8'(driveSel), 8'h4);
    clearIrq();
    snapKeep = readySnap;
    rwActive = 1'b1;
    step(2 * SLOT);
    check("R7 rw sel", 8'(driveSel), 8'h6);
    check("R7 rw snap", 8'(readySnap), 8'(snapKeep));
    rwActive = 1'b0;
    // R10 R3 minifloppy doubles the slot
    readyIn = 4'b0000;
    loadCfg(1'b0, 1'b1);
    softReset();
    step(2 * SLOT - 1);
    check("R3 mini hold", 8'(driveSel), 8'h1);
    step(1);
    check("R10 R3 mini step", 8'(driveSel), 8'h2);
    // R8 R9 PC AT mode survives soft reset, sampling continues
    loadCfg(1'b1, 1'b1);
    readyIn = 4'b0001;
    softReset();
    check("R9 R8 at sel", 8'(driveSel), 8'h6);
    step(2 * SLOT);
    check("R8 irq", 8'(irqOut), 8'h1);
    check("R8 sel hidden", 8'(driveSel), 8'h6);
    // R9 hardware reset returns to base mode, standard rate
    hwRst = 1'b1; step(1); hwRst = 1'b0;
    check("R9 base sel", 8'(driveSel), 8'h1);
    check("R9 irq cleared", 8'(irqOut), 8'h0);
    step(SLOT);
    check("R9 std rate", 8'(driveSel), 8'h2);
    check("R9 irq", 8'(irqOut), 8'h1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule